// File: doc/BRIEF.md
# Oversampling Serial Receiver

This block turns an asynchronous serial line into parallel words. The raw line first passes a two-flop synchronizer. The receiver then runs from a sixteen-times-baud enable pulse that is counted down from the system clock. A falling edge seen while idle starts a frame. Each bit is then sampled once, at its centre. Every logic element runs on the one system clock with a synchronous reset, and no divided clock exists anywhere in the design.

A frame consists of a low start bit, then `DATA_BITS` data bits with the least significant bit first, then a high stop bit. When the stop bit reads high, the assembled word appears on `rx_data` and `rx_valid` pulses for one clock. When the stop bit reads low, `frame_err` pulses instead. A start bit that has vanished by its centre is treated as noise and discarded. Clock frequency, baud rate and word width are parameters, so the same source serves slow and fast links.

Top module: `serial_rx`

## Requirements
- R1: The raw line passes two flops in series before any other logic uses it, and both flops reset to the idle-high level. A line held high across reset release therefore starts no frame.
- R2: The oversample enable is a single-cycle pulse issued once every CLK_FREQ/(BAUD*16) system clocks. The receiver advances only on this enable and uses no derived clock.
- R3: A frame begins only when the synchronized line goes from high to low while the receiver is idle.
- R4: At the 8th enable pulse after the start edge (the start-bit centre), the receiver samples the line. If it reads high, the receiver returns to idle and produces neither a word nor an error.
- R5: Each data bit is sampled 16 enable pulses after the previous sample, and the first sample is the least significant bit. If the stop bit samples high, `rx_data` takes the word and `rx_valid` is high for exactly one clock.
- R6: If the stop bit samples low, `frame_err` is high for exactly one clock and `rx_valid` stays low. `rx_data` keeps its previous value, and the receiver waits for the line to return high before it accepts a new start edge.
- R7: Frames sent back to back, with each start bit immediately following the previous stop bit, are each received correctly.
- R8: A sender whose bit period differs by up to about 3% from the nominal one is received correctly.
- R9: Synchronous reset, including a reset asserted in the middle of a frame, returns the receiver to idle, clears `rx_data` to zero and holds `rx_valid` and `frame_err` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| rx_data | output | DATA_BITS | Last word received with a valid stop bit |
| rx_valid | output | 1 | One-clock strobe when a new word is on rx_data |
| frame_err | output | 1 | One-clock strobe when a stop bit is sampled low |

## Verification
Several properties are checked on every cycle. The synchronized line must equal the raw line two clocks earlier, and enable pulses must be exactly the configured distance apart. Both strobes must last a single clock, must never coincide, and must agree with the stop-bit level sampled one clock before them. Reset must force both strobes low. Other behaviours can only be shown by whole frames, so the bench scenarios cover them: bit order, glitch rejection, recovery after a framing error, back-to-back timing, tolerance of sender rate mismatch, and the cleared word after a mid-frame reset.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_START = 3'd1,
        ST_DATA  = 3'd2,
        ST_STOP  = 3'd3,
        ST_HOLD  = 3'd4
    } rx_state_e;

    localparam int unsigned OVERSAMPLE = 16;
endpackage

// File: rtl/rx_sync_2ff.sv
module rx_sync_2ff #(
    parameter logic IDLE_LEVEL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d_in,
    output logic q_out
);
    typedef struct packed {
        logic s1;
        logic s2;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d    = sync_q;
        sync_d.s1 = d_in;
        sync_d.s2 = sync_q.s1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '{s1: IDLE_LEVEL, s2: IDLE_LEVEL};
        end else begin
            sync_q <= sync_d;
        end
    end

    assign q_out = sync_q.s2;
endmodule

// File: rtl/rx_tick_gen.sv
module rx_tick_gen #(
    parameter int unsigned DIV = 27
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;

    generate
        if (DIV > 1) begin : g_count
            logic [CW-1:0] cnt_d, cnt_q;
            logic          tick_d, tick_q;

            always_comb begin
                tick_d = 1'b0;
                if (cnt_q == CW'(DIV - 1)) begin
                    cnt_d  = '0;
                    tick_d = 1'b1;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    cnt_q  <= '0;
                    tick_q <= 1'b0;
                end else begin
                    cnt_q  <= cnt_d;
                    tick_q <= tick_d;
                end
            end

            assign tick = tick_q;
        end else begin : g_every
            logic tick_q;
            always_ff @(posedge clk) begin
                if (rst) tick_q <= 1'b0;
                else     tick_q <= 1'b1;
            end
            assign tick = tick_q;
        end
    endgenerate
endmodule

// File: rtl/rx_fall_det.sv
module rx_fall_det (
    input  logic clk,
    input  logic rst,
    input  logic line,
    output logic fall
);
    logic prev_d, prev_q;

    always_comb prev_d = line;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b1;
        else     prev_q <= prev_d;
    end

    assign fall = prev_q & ~line;
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
    import serial_rx_pkg::*;
#(
    parameter int unsigned DATA_BITS = 8,
    parameter int unsigned OVS       = OVERSAMPLE
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  logic                 line,
    input  logic                 fall,
    output logic [DATA_BITS-1:0] word,
    output logic                 valid,
    output logic                 ferr
);
    localparam int unsigned TW   = $clog2(OVS);
    localparam int unsigned BW   = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
    localparam int unsigned HALF = OVS / 2;

    typedef struct packed {
        rx_state_e            st;
        logic [TW-1:0]        tcnt;
        logic [BW-1:0]        bcnt;
        logic [DATA_BITS-1:0] shreg;
        logic [DATA_BITS-1:0] dout;
        logic                 vld;
        logic                 err;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    always_comb begin
        fsm_d     = fsm_q;
        fsm_d.vld = 1'b0;
        fsm_d.err = 1'b0;
        case (fsm_q.st)
            ST_IDLE: begin
                if (fall) begin
                    fsm_d.st   = ST_START;
                    fsm_d.tcnt = '0;
                end
            end
            ST_START: begin
                if (tick) begin
                    if (fsm_q.tcnt == TW'(HALF - 1)) begin
                        fsm_d.tcnt = '0;
                        fsm_d.bcnt = '0;
                        fsm_d.st   = line ? ST_IDLE : ST_DATA;
                    end else begin
                        fsm_d.tcnt = fsm_q.tcnt + 1'b1;
                    end
                end
            end
            ST_DATA: begin
                if (tick) begin
                    if (fsm_q.tcnt == TW'(OVS - 1)) begin
                        fsm_d.tcnt  = '0;
                        fsm_d.shreg = {line, fsm_q.shreg[DATA_BITS-1:1]};
                        if (fsm_q.bcnt == BW'(DATA_BITS - 1)) begin
                            fsm_d.st = ST_STOP;
                        end else begin
                            fsm_d.bcnt = fsm_q.bcnt + 1'b1;
                        end
                    end else begin
                        fsm_d.tcnt = fsm_q.tcnt + 1'b1;
                    end
                end
            end
            ST_STOP: begin
                if (tick) begin
                    if (fsm_q.tcnt == TW'(OVS - 1)) begin
                        fsm_d.tcnt = '0;
                        if (line) begin
                            fsm_d.dout = fsm_q.shreg;
                            fsm_d.vld  = 1'b1;
                            fsm_d.st   = ST_IDLE;
                        end else begin
                            fsm_d.err = 1'b1;
                            fsm_d.st  = ST_HOLD;
                        end
                    end else begin
                        fsm_d.tcnt = fsm_q.tcnt + 1'b1;
                    end
                end
            end
            ST_HOLD: begin
                if (line) fsm_d.st = ST_IDLE;
            end
            default: fsm_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fsm_q <= '{st: ST_IDLE, tcnt: '0, bcnt: '0, shreg: '0,
                       dout: '0, vld: 1'b0, err: 1'b0};
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign word  = fsm_q.dout;
    assign valid = fsm_q.vld;
    assign ferr  = fsm_q.err;
endmodule

// File: rtl/serial_rx.sv
module serial_rx
    import serial_rx_pkg::*;
#(
    parameter int unsigned CLK_FREQ  = 50_000_000,
    parameter int unsigned BAUD      = 115_200,
    parameter int unsigned DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 rx_line,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 rx_valid,
    output logic                 frame_err
);
    localparam int unsigned DIV_RAW = CLK_FREQ / (BAUD * OVERSAMPLE);
    localparam int unsigned DIV     = (DIV_RAW < 1) ? 1 : DIV_RAW;

    logic line_s;
    logic tick;
    logic fall;

    rx_sync_2ff #(.IDLE_LEVEL(1'b1)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .d_in  (rx_line),
        .q_out (line_s)
    );

    rx_tick_gen #(.DIV(DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    rx_fall_det u_edge (
        .clk  (clk),
        .rst  (rst),
        .line (line_s),
        .fall (fall)
    );

    rx_frame_fsm #(.DATA_BITS(DATA_BITS), .OVS(OVERSAMPLE)) u_fsm (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .line  (line_s),
        .fall  (fall),
        .word  (rx_data),
        .valid (rx_valid),
        .ferr  (frame_err)
    );
endmodule

// File: rtl/serial_rx_checker.sv
module serial_rx_checker #(
    parameter int unsigned DIV = 27
) (
    input logic clk,
    input logic rst,
    input logic rx_line,
    input logic line_s,
    input logic tick,
    input logic rx_valid,
    input logic frame_err
);
    int unsigned gap_q;
    logic        seen_q;
    int unsigned cyc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q  <= 0;
            seen_q <= 1'b0;
            cyc_q  <= 0;
        end else begin
            if (cyc_q < 3) cyc_q <= cyc_q + 1;
            if (tick) begin
                gap_q  <= 0;
                seen_q <= 1'b1;
            end else begin
                gap_q <= gap_q + 1;
            end
        end
    end

    // R1: synchronized line lags the raw line by two clocks
    p_sync_delay_r1: assert property (@(posedge clk) disable iff (rst)
        (cyc_q >= 2) |-> (line_s == $past(rx_line, 2)));

    // R2: enable pulses exactly DIV clocks apart
    p_tick_spacing_r2: assert property (@(posedge clk) disable iff (rst)
        (tick && seen_q) |-> (gap_q == DIV - 1));

    // R5: valid strobe lasts one clock
    p_valid_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    // R5: valid only after a high stop sample
    p_valid_stop_high_r5: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> $past(line_s));

    // R6: error strobe lasts one clock
    p_err_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        frame_err |=> !frame_err);

    // R6: error only after a low stop sample, never with valid
    p_err_stop_low_r6: assert property (@(posedge clk) disable iff (rst)
        frame_err |-> (!$past(line_s) && !rx_valid));

    // R9: reset clears both strobes
    p_reset_quiet_r9: assert property (@(posedge clk)
        rst |=> (!rx_valid && !frame_err));
endmodule

bind serial_rx serial_rx_checker #(.DIV(DIV)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .rx_line   (rx_line),
    .line_s    (line_s),
    .tick      (tick),
    .rx_valid  (rx_valid),
    .frame_err (frame_err)
);

// File: tb/test_serial_rx.sv
module test_serial_rx;
    localparam int CLK_PERIOD = 10;
    localparam int CLK_HZ     = 640_000;
    localparam int BAUD_RATE  = 10_000;
    localparam int BIT_CYC    = CLK_HZ / BAUD_RATE;
    localparam int NVEC       = 6;

    localparam logic [7:0] VEC_BYTE [NVEC] = '{8'h55, 8'h01, 8'h80, 8'hFF, 8'h00, 8'hA7};
    localparam int         VEC_PER  [NVEC] = '{BIT_CYC, BIT_CYC, BIT_CYC,
                                              BIT_CYC - 2, BIT_CYC + 2, BIT_CYC - 2};

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_line = 1'b1;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic       frame_err;

    int n_checks = 0;
    int n_fail   = 0;
    int n_valid  = 0;
    int n_err    = 0;
    logic [7:0] last_data = '0;
    logic done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    serial_rx #(.CLK_FREQ(CLK_HZ), .BAUD(BAUD_RATE), .DATA_BITS(8)) i_serial_rx (
        .clk       (clk),
        .rst       (rst),
        .rx_line   (rx_line),
        .rx_data   (rx_data),
        .rx_valid  (rx_valid),
        .frame_err (frame_err)
    );

    always @(negedge clk) begin
        if (!rst && rx_valid) begin
            n_valid   <= n_valid + 1;
            last_data <= rx_data;
        end
        if (!rst && frame_err) n_err <= n_err + 1;
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic hold_bit(input logic b, input int per);
        rx_line = b;
        repeat (per) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d, input int per, input logic stop_lvl);
        hold_bit(1'b0, per);
        for (int i = 0; i < 8; i++) hold_bit(d[i], per);
        hold_bit(stop_lvl, per);
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin
        repeat (200_000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        int base_v;
        int base_e;
        rst = 1'b1;
        rx_line = 1'b1;
        repeat (5) @(negedge clk);
        // R9 reset state
        check(rx_valid == 1'b0, "R9 reset valid", 32'(rx_valid), 0);
        check(frame_err == 1'b0, "R9 reset err", 32'(frame_err), 0);
        check(rx_data == 8'h00, "R9 reset data", 32'(rx_data), 0);
        rst = 1'b0;
        repeat (3 * BIT_CYC) @(negedge clk);
        // R1: idle-high line across reset release starts nothing
        check(n_valid == 0 && n_err == 0, "R1 no spurious frame", 32'(n_valid + n_err), 0);

        // Table walk: back to back, LSB first, rate mismatch
        base_v = n_valid;
        for (int i = 0; i < NVEC; i++) begin
            send(VEC_BYTE[i], VEC_PER[i], 1'b1);
            check(n_valid == base_v + i + 1, "R3 R7 frame count",
                  32'(n_valid), 32'(base_v + i + 1));
            check(last_data == VEC_BYTE[i], (VEC_PER[i] == BIT_CYC) ?
                  "R2 R5 nominal word" : "R8 mismatched word",
                  32'(last_data), 32'(VEC_BYTE[i]));
        end
        check(n_err == 0, "R7 no error in stream", 32'(n_err), 0);

        // R4 glitch: short low pulse
        repeat (2 * BIT_CYC) @(negedge clk);
        base_v = n_valid;
        base_e = n_err;
        hold_bit(1'b0, 12);
        hold_bit(1'b1, 12 * BIT_CYC);
        check(n_valid == base_v, "R4 glitch no word", 32'(n_valid), 32'(base_v));
        check(n_err == base_e, "R4 glitch no error", 32'(n_err), 32'(base_e));
        send(8'h3E, BIT_CYC, 1'b1);
        check(last_data == 8'h3E, "R4 recovery word", 32'(last_data), 32'h3E);

        // R6 framing error, then line held low
        base_v = n_valid;
        base_e = n_err;
        send(8'hC3, BIT_CYC, 1'b0);
        hold_bit(1'b0, 3 * BIT_CYC);
        check(n_err == base_e + 1, "R6 error strobe", 32'(n_err), 32'(base_e + 1));
        check(n_valid == base_v, "R6 no valid", 32'(n_valid), 32'(base_v));
        check(rx_data == 8'h3E, "R6 data kept", 32'(rx_data), 32'h3E);
        hold_bit(1'b1, 2 * BIT_CYC);
        check(n_valid == base_v && n_err == base_e + 1, "R6 hold no new frame",
              32'(n_valid), 32'(base_v));
        send(8'h69, BIT_CYC, 1'b1);
        check(last_data == 8'h69, "R6 rearmed word", 32'(last_data), 32'h69);

        // R9 reset mid-frame
        hold_bit(1'b1, BIT_CYC);
        base_v = n_valid;
        base_e = n_err;
        hold_bit(1'b0, BIT_CYC);
        hold_bit(1'b1, BIT_CYC);
        hold_bit(1'b0, 2 * BIT_CYC);
        rx_line = 1'b1;
        rst = 1'b1;
        repeat (4) @(negedge clk);
        check(rx_data == 8'h00, "R9 mid-frame data cleared", 32'(rx_data), 0);
        check(rx_valid == 1'b0 && frame_err == 1'b0, "R9 mid-frame strobes",
              32'({rx_valid, frame_err}), 0);
        rst = 1'b0;
        repeat (12 * BIT_CYC) @(negedge clk);
        check(n_valid == base_v && n_err == base_e, "R9 no output after reset",
              32'(n_valid + n_err), 32'(base_v + base_e));
        send(8'h5A, BIT_CYC, 1'b1);
        check(last_data == 8'h5A && n_valid == base_v + 1, "R9 word after reset",
              32'(last_data), 32'h5A);

        repeat (BIT_CYC) @(negedge clk);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule